// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Sequencer

This block sits between a clocked host and an external asynchronous static RAM of 2048 bytes. The host presents one byte-wide read or write at a time with a request/ready handshake; the block turns each request into a chip select, write enable and output enable sequence on the memory pins. It also drives the direction control and outgoing value of the shared data bus. Each phase of the sequence lasts a parameterised number of clock cycles. Those counts come from the memory's nanosecond timing rounded up at the chosen clock period.

A write is ordered so that the address settles before the write strobe falls and stays put until after it rises. The data bus is driven only inside a window that covers the data setup before the end of the strobe and the data hold after it. A parameter keeps output enable low during writes. In that case the strobe is stretched so that the memory's own output driver has turned off before the block starts driving. A read holds select and output enable low for the access time, captures the bus on the last cycle and returns the byte with a one-cycle valid pulse.

Top module: `async_sram_ctrl`

## Requirements
- R1: In reset and whenever no transfer is in progress, host_ready is 1, mem_cs_n, mem_we_n and mem_oe_n are all 1, mem_dq_oe is 0 and host_rvalid is 0.
- R2: A request is taken at a rising edge where host_req and host_ready are both 1. host_ready is 0 from the next cycle through the last cycle of the transfer. After every transfer there is at least one cycle with host_ready at 1 before the next transfer starts.
- R3: A write shows three phases in order. The setup phase lasts AS_CYC cycles with mem_cs_n 0 and mem_we_n 1. The strobe phase has mem_cs_n 0 and mem_we_n 0. The recovery phase lasts max(WR_CYC, DH_CYC) cycles with mem_cs_n 0 and mem_we_n 1. The block then returns to idle.
- R4: mem_addr takes the value of host_addr (11 bits, 0 to 2047) when a request is taken and holds it until the next accepted request. It never changes in a cycle where mem_we_n is 0 or in the cycle after one.
- R5: During a write, mem_dq_oe is 1 with mem_dq_out equal to the accepted write byte for at least DW_CYC cycles ending at the rise of mem_we_n. It stays 1 for exactly DH_CYC cycles after that rise, and is 0 at all other times.
- R6: With OE_IN_WRITE = 0, mem_oe_n stays 1 for the whole write, the strobe lasts max(WP_CYC, DW_CYC) cycles, and the bus is driven throughout it. With OE_IN_WRITE = 1, mem_oe_n is 0 in the setup and strobe phases. The strobe then lasts max(WP_CYC, OFF_CYC + DW_CYC) cycles, and the bus is not driven in its first OFF_CYC cycles.
- R7: A read holds mem_cs_n 0, mem_oe_n 0 and mem_we_n 1 for ACC_CYC cycles. mem_dq_in is captured at the edge that ends the last of them. host_rvalid is then 1 for exactly the next cycle, with host_rdata equal to the captured byte.
- R8: mem_dq_oe is never 1 while mem_cs_n is 0, mem_oe_n is 0 and mem_we_n is 1. mem_dq_oe is 0 in the cycle before any fall of mem_oe_n.
- R9: host_req while host_ready is 0 is ignored: no transfer is started and no memory location is changed by it.
- R10: A read of an address returns the last byte written to that address through the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Transfer request |
| host_wr | input | 1 | 1 for write, 0 for read |
| host_addr | input | ADDR_W | Byte address |
| host_wdata | input | DATA_W | Write byte |
| host_ready | output | 1 | Block idle, request may be taken |
| host_rdata | output | DATA_W | Last byte read |
| host_rvalid | output | 1 | One-cycle pulse when host_rdata is new |
| mem_addr | output | ADDR_W | Memory address pins |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_out | output | DATA_W | Value for the data bus when driven |
| mem_dq_oe | output | 1 | 1 drives the data bus from mem_dq_out |
| mem_dq_in | input | DATA_W | Value seen on the data bus |

## Verification
The bench builds the block with OE_IN_WRITE = 1, WP_CYC = 2, OFF_CYC = 2, DW_CYC = 2, AS_CYC = 1, WR_CYC = 3, DH_CYC = 1 and ACC_CYC = 2. With these values the turn-off term, not the nominal width, sets the 4-cycle strobe, so the stretch and the undriven head of the strobe are exercised. Recovery outlasts the data hold, so the bus is released while select is still low. A short access makes a read right after a write test the bus turnaround. Addresses span 0 through 2047, and requests are held high during busy transfers to show that they are ignored.

// File: rtl/asram_pkg.sv
package asram_pkg;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_WSET = 3'd1,
      ST_WPUL = 3'd2,
      ST_WREC = 3'd3,
      ST_RACC = 3'd4
   } asram_state_e;

   function automatic int unsigned cyc_max(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/asram_timer.sv
// Phase down-counter: loaded with (phase length - 1) on entry, counts to zero.
module asram_timer #(
   parameter int unsigned CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] cnt,
   output logic             zero
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign cnt  = cnt_q;
   assign zero = (cnt_q == '0);

endmodule

// File: rtl/asram_fsm.sv
// Transfer sequencer: phase order, timer reloads and strobe decode.
module asram_fsm
   import asram_pkg::*;
#(
   parameter int unsigned AS_CYC      = 1,
   parameter int unsigned PULSE_CYC   = 3,
   parameter int unsigned REC_CYC     = 1,
   parameter int unsigned ACC_CYC     = 5,
   parameter int unsigned DRV_SKIP    = 0,
   parameter int unsigned DH_CYC      = 1,
   parameter bit          OE_IN_WRITE = 1'b0,
   parameter int unsigned CNT_W       = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req,
   input  logic             wr,
   input  logic [CNT_W-1:0] tmr_cnt,
   input  logic             tmr_zero,
   output logic             tmr_load,
   output logic [CNT_W-1:0] tmr_val,
   output logic             accept,
   output logic             sample,
   output logic             ready,
   output logic             cs_n,
   output logic             we_n,
   output logic             oe_n,
   output logic             dq_oe
);

   localparam logic [CNT_W-1:0] AS_LD    = CNT_W'(AS_CYC - 1);
   localparam logic [CNT_W-1:0] PUL_LD   = CNT_W'(PULSE_CYC - 1);
   localparam logic [CNT_W-1:0] REC_LD   = CNT_W'(REC_CYC - 1);
   localparam logic [CNT_W-1:0] ACC_LD   = CNT_W'(ACC_CYC - 1);
   localparam logic [CNT_W-1:0] DRV_LAST = CNT_W'(PULSE_CYC - 1 - DRV_SKIP);
   localparam logic [CNT_W-1:0] HOLD_MIN = CNT_W'(REC_CYC - DH_CYC);

   asram_state_e st_q, st_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= ST_IDLE;
      end else begin
         st_q <= st_d;
      end
   end

   always_comb begin
      st_d     = st_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      accept   = 1'b0;
      sample   = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            if (req) begin
               accept   = 1'b1;
               tmr_load = 1'b1;
               if (wr) begin
                  st_d    = ST_WSET;
                  tmr_val = AS_LD;
               end else begin
                  st_d    = ST_RACC;
                  tmr_val = ACC_LD;
               end
            end
         end
         ST_WSET: begin
            if (tmr_zero) begin
               st_d     = ST_WPUL;
               tmr_load = 1'b1;
               tmr_val  = PUL_LD;
            end
         end
         ST_WPUL: begin
            if (tmr_zero) begin
               st_d     = ST_WREC;
               tmr_load = 1'b1;
               tmr_val  = REC_LD;
            end
         end
         ST_WREC: begin
            if (tmr_zero) begin
               st_d = ST_IDLE;
            end
         end
         ST_RACC: begin
            if (tmr_zero) begin
               st_d   = ST_IDLE;
               sample = 1'b1;
            end
         end
         default: st_d = ST_IDLE;
      endcase
   end

   logic in_wset, in_wpul, in_wrec, in_racc;
   assign in_wset = (st_q == ST_WSET);
   assign in_wpul = (st_q == ST_WPUL);
   assign in_wrec = (st_q == ST_WREC);
   assign in_racc = (st_q == ST_RACC);

   // Output-enable policy during writes and the undriven head of the strobe.
   logic oe_wr, pul_drive, rec_drive;
   if (OE_IN_WRITE) begin : g_oe_low
      assign oe_wr     = in_wset | in_wpul;
      assign pul_drive = (tmr_cnt <= DRV_LAST);
   end else begin : g_oe_high
      assign oe_wr     = 1'b0;
      assign pul_drive = 1'b1;
   end

   // Data hold window at the start of recovery.
   if (DH_CYC == 0) begin : g_no_hold
      assign rec_drive = 1'b0;
   end else if (DH_CYC >= REC_CYC) begin : g_full_hold
      assign rec_drive = 1'b1;
   end else begin : g_part_hold
      assign rec_drive = (tmr_cnt >= HOLD_MIN);
   end

   assign ready = (st_q == ST_IDLE);
   assign cs_n  = ready;
   assign we_n  = ~in_wpul;
   assign oe_n  = ~(in_racc | oe_wr);
   assign dq_oe = (in_wpul & pul_drive) | (in_wrec & rec_drive);

endmodule

// File: rtl/asram_dpath.sv
// Address/data capture at accept, read capture and valid pulse.
module asram_dpath #(
   parameter int unsigned ADDR_W = 11,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic              sample,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   input  logic [DATA_W-1:0] mem_dq_in,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic [DATA_W-1:0] rdata,
   output logic              rvalid
);

   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdat_q;
   logic [DATA_W-1:0] rdat_q;
   logic              rval_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         wdat_q <= '0;
      end else if (accept) begin
         addr_q <= host_addr;
         wdat_q <= host_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdat_q <= '0;
         rval_q <= 1'b0;
      end else begin
         rval_q <= sample;
         if (sample) begin
            rdat_q <= mem_dq_in;
         end
      end
   end

   assign mem_addr   = addr_q;
   assign mem_dq_out = wdat_q;
   assign rdata      = rdat_q;
   assign rvalid     = rval_q;

endmodule

// File: rtl/async_sram_ctrl.sv
module async_sram_ctrl
   import asram_pkg::*;
#(
   parameter int unsigned ADDR_W      = 11,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned AS_CYC      = 1,
   parameter int unsigned WP_CYC      = 3,
   parameter int unsigned OFF_CYC     = 2,
   parameter int unsigned DW_CYC      = 2,
   parameter int unsigned WR_CYC      = 1,
   parameter int unsigned DH_CYC      = 1,
   parameter int unsigned ACC_CYC     = 5,
   parameter bit          OE_IN_WRITE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_req,
   input  logic              host_wr,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   output logic              host_ready,
   output logic [DATA_W-1:0] host_rdata,
   output logic              host_rvalid,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_cs_n,
   output logic              mem_we_n,
   output logic              mem_oe_n,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_in
);

   localparam int unsigned PULSE_CYC = OE_IN_WRITE ? cyc_max(WP_CYC, OFF_CYC + DW_CYC)
                                                   : cyc_max(WP_CYC, DW_CYC);
   localparam int unsigned DRV_SKIP  = OE_IN_WRITE ? OFF_CYC : 0;
   localparam int unsigned REC_CYC   = cyc_max(WR_CYC, DH_CYC);
   localparam int unsigned MAX_CYC   = cyc_max(cyc_max(AS_CYC, PULSE_CYC), cyc_max(REC_CYC, ACC_CYC));
   localparam int unsigned CNT_W     = $clog2(MAX_CYC + 1);

   // Elaboration-time parameter checks
   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("async_sram_ctrl: ADDR_W and DATA_W must be at least 1");
   end
   if (AS_CYC < 1 || WP_CYC < 1 || ACC_CYC < 1 || WR_CYC < 1) begin : g_bad_phase
      $error("async_sram_ctrl: setup, strobe, recovery and access phases need at least one cycle");
   end
   if (DW_CYC < 1) begin : g_bad_dw
      $error("async_sram_ctrl: DW_CYC must be at least 1");
   end

   logic             tmr_load, tmr_zero, accept, sample;
   logic [CNT_W-1:0] tmr_val, tmr_cnt;

   asram_timer #(
      .CNT_W (CNT_W)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .cnt      (tmr_cnt),
      .zero     (tmr_zero)
   );

   asram_fsm #(
      .AS_CYC      (AS_CYC),
      .PULSE_CYC   (PULSE_CYC),
      .REC_CYC     (REC_CYC),
      .ACC_CYC     (ACC_CYC),
      .DRV_SKIP    (DRV_SKIP),
      .DH_CYC      (DH_CYC),
      .OE_IN_WRITE (OE_IN_WRITE),
      .CNT_W       (CNT_W)
   ) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (host_req),
      .wr       (host_wr),
      .tmr_cnt  (tmr_cnt),
      .tmr_zero (tmr_zero),
      .tmr_load (tmr_load),
      .tmr_val  (tmr_val),
      .accept   (accept),
      .sample   (sample),
      .ready    (host_ready),
      .cs_n     (mem_cs_n),
      .we_n     (mem_we_n),
      .oe_n     (mem_oe_n),
      .dq_oe    (mem_dq_oe)
   );

   asram_dpath #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_dpath (
      .clk        (clk),
      .rst_n      (rst_n),
      .accept     (accept),
      .sample     (sample),
      .host_addr  (host_addr),
      .host_wdata (host_wdata),
      .mem_dq_in  (mem_dq_in),
      .mem_addr   (mem_addr),
      .mem_dq_out (mem_dq_out),
      .rdata      (host_rdata),
      .rvalid     (host_rvalid)
   );

endmodule

// File: rtl/asram_chk.sv
module asram_chk
   import asram_pkg::*;
#(
   parameter int unsigned ADDR_W      = 11,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned WP_CYC      = 3,
   parameter int unsigned OFF_CYC     = 2,
   parameter int unsigned DW_CYC      = 2,
   parameter int unsigned DH_CYC      = 1,
   parameter bit          OE_IN_WRITE = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              host_ready,
   input logic              host_rvalid,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_cs_n,
   input logic              mem_we_n,
   input logic              mem_oe_n,
   input logic [DATA_W-1:0] mem_dq_out,
   input logic              mem_dq_oe
);

   localparam int unsigned PULSE_MIN = OE_IN_WRITE ? cyc_max(WP_CYC, OFF_CYC + DW_CYC)
                                                   : cyc_max(WP_CYC, DW_CYC);

   logic [15:0] we_low_cnt, drv_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         we_low_cnt <= '0;
         drv_cnt    <= '0;
      end else if (!mem_we_n) begin
         if (we_low_cnt != '1) we_low_cnt <= we_low_cnt + 1'b1;
         if (!mem_dq_oe)       drv_cnt <= '0;
         else if (drv_cnt != '1) drv_cnt <= drv_cnt + 1'b1;
      end else begin
         we_low_cnt <= '0;
         drv_cnt    <= '0;
      end
   end

   AST_IDLE_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
      host_ready |-> mem_cs_n); // R1
   AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      mem_cs_n |-> (mem_we_n && mem_oe_n && !mem_dq_oe)); // R1
   AST_ADDR_ONLY_AT_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(mem_addr) |-> $past(host_ready)); // R2
   AST_ADDR_WE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(mem_addr) |-> (mem_we_n && $past(mem_we_n))); // R4
   AST_DATA_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> (drv_cnt >= 16'(DW_CYC))); // R5
   AST_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out)); // R5
   if (DH_CYC > 0) begin : g_hold_chk
      AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(mem_we_n) |-> mem_dq_oe); // R5
   end
   AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> (we_low_cnt >= 16'(PULSE_MIN))); // R6
   AST_RVALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      host_rvalid |=> !host_rvalid); // R7
   AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_cs_n && !mem_oe_n && mem_we_n) |-> !mem_dq_oe); // R8
   AST_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_oe_n) |-> !$past(mem_dq_oe)); // R8

endmodule

bind async_sram_ctrl asram_chk #(
   .ADDR_W      (ADDR_W),
   .DATA_W      (DATA_W),
   .WP_CYC      (WP_CYC),
   .OFF_CYC     (OFF_CYC),
   .DW_CYC      (DW_CYC),
   .DH_CYC      (DH_CYC),
   .OE_IN_WRITE (OE_IN_WRITE)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .host_ready  (host_ready),
   .host_rvalid (host_rvalid),
   .mem_addr    (mem_addr),
   .mem_cs_n    (mem_cs_n),
   .mem_we_n    (mem_we_n),
   .mem_oe_n    (mem_oe_n),
   .mem_dq_out  (mem_dq_out),
   .mem_dq_oe   (mem_dq_oe)
);

// File: tb/async_sram_ctrl_tb.sv
module async_sram_ctrl_tb;

   localparam int AW   = 11;
   localparam int DW   = 8;
   localparam int T_AS = 1;
   localparam int T_WP = 2;
   localparam int T_OF = 2;
   localparam int T_DS = 2;
   localparam int T_WR = 3;
   localparam int T_DH = 1;
   localparam int T_AC = 2;
   localparam bit OEW  = 1'b1;
   // strobe length and recovery length worked out from R3/R6
   localparam int PUL  = (OEW ? ((T_WP > T_OF + T_DS) ? T_WP : T_OF + T_DS)
                              : ((T_WP > T_DS) ? T_WP : T_DS));
   localparam int SKIP = OEW ? T_OF : 0;
   localparam int REC  = (T_WR > T_DH) ? T_WR : T_DH;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          host_req = 1'b0;
   logic          host_wr = 1'b0;
   logic [AW-1:0] host_addr = '0;
   logic [DW-1:0] host_wdata = '0;
   logic          host_ready, host_rvalid;
   logic [DW-1:0] host_rdata;
   logic [AW-1:0] mem_addr;
   logic          mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
   logic [DW-1:0] mem_dq_out, mem_dq_in;

   always #2.5 clk = ~clk;

   async_sram_ctrl #(
      .ADDR_W(AW), .DATA_W(DW), .AS_CYC(T_AS), .WP_CYC(T_WP), .OFF_CYC(T_OF),
      .DW_CYC(T_DS), .WR_CYC(T_WR), .DH_CYC(T_DH), .ACC_CYC(T_AC), .OE_IN_WRITE(OEW)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_wr(host_wr),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_ready(host_ready),
      .host_rdata(host_rdata), .host_rvalid(host_rvalid), .mem_addr(mem_addr),
      .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
      .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
   );

   // Behavioural memory on the pins
   logic [DW-1:0] mdl_mem [0:2047];
   logic [DW-1:0] ref_mem [0:2047];
   assign mem_dq_in = (!mem_cs_n && !mem_oe_n && mem_we_n) ? mdl_mem[mem_addr] : 8'hA5;
   always @(posedge clk) begin
      if (!mem_cs_n && !mem_we_n && mem_dq_oe) mdl_mem[mem_addr] <= mem_dq_out;
   end

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit run_chk = 1'b0;

   typedef struct packed {
      logic          rdy;
      logic          cs_n;
      logic          we_n;
      logic          oe_n;
      logic          dqe;
      logic          rv;
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      logic [3:0]    kind;
   } vec_t;

   vec_t          exp_q[$];
   logic          cur_rdy = 1'b1;
   logic [AW-1:0] last_addr = '0;

   function automatic vec_t mk(input logic rdy, cs_n, we_n, oe_n, dqe, rv,
                               input logic [AW-1:0] a, input logic [DW-1:0] d,
                               input logic [3:0] kind);
      vec_t v;
      v.rdy = rdy; v.cs_n = cs_n; v.we_n = we_n; v.oe_n = oe_n; v.dqe = dqe;
      v.rv = rv; v.a = a; v.d = d; v.kind = kind;
      return v;
   endfunction

   // Reference model: a taken request expands into its per-cycle expectation
   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (rst_n && run_chk && host_req && cur_rdy) begin
         last_addr = host_addr;
         if (host_wr) begin
            for (int i = 0; i < T_AS; i++)
               exp_q.push_back(mk(0, 0, 1, OEW ? 1'b0 : 1'b1, 0, 0, host_addr, host_wdata, 3));
            for (int i = 0; i < PUL; i++)
               exp_q.push_back(mk(0, 0, 0, OEW ? 1'b0 : 1'b1, (i >= SKIP), 0, host_addr, host_wdata, 6));
            for (int i = 0; i < REC; i++)
               exp_q.push_back(mk(0, 0, 1, 1, (i < T_DH), 0, host_addr, host_wdata, 3));
            ref_mem[host_addr] = host_wdata;
         end else begin
            for (int i = 0; i < T_AC; i++)
               exp_q.push_back(mk(0, 0, 1, 0, 0, 0, host_addr, '0, 7));
            exp_q.push_back(mk(1, 1, 1, 1, 0, 1, host_addr, ref_mem[host_addr], 7));
         end
      end
   end

   // Per-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (run_chk) begin
         vec_t e;
         int   tag;
         logic dq_bad, rv_bad, rd_bad;
         e = (exp_q.size() > 0) ? exp_q.pop_front() : mk(1, 1, 1, 1, 0, 0, last_addr, '0, 1);
         cur_rdy = e.rdy;
         dq_bad = (mem_dq_oe !== e.dqe) || (e.dqe && mem_dq_out !== e.d);
         rv_bad = (host_rvalid !== e.rv);
         rd_bad = e.rv && (host_rdata !== e.d);
         checks++;
         if (host_ready !== e.rdy)      tag = 2;          // R2 handshake
         else if (mem_addr !== e.a)     tag = 4;          // R4 address hold
         else if (dq_bad)               tag = (e.kind == 7) ? 8 : 5; // R8 / R5
         else if (rv_bad)               tag = 7;          // R7 valid pulse
         else if (rd_bad)               tag = 10;         // R10 data
         else if ({mem_cs_n, mem_we_n, mem_oe_n} !== {e.cs_n, e.we_n, e.oe_n})
                                        tag = e.kind;     // R1 idle, R3 write, R6 strobe, R7 read
         else                           tag = 0;
         if (tag != 0) begin
            errors++;
            $display("FAIL R%0d cycle %0d: got rdy=%b cs=%b we=%b oe=%b dqe=%b rv=%b a=%h dq=%h rd=%h exp rdy=%b cs=%b we=%b oe=%b dqe=%b rv=%b a=%h d=%h",
                     tag, cyc, host_ready, mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe, host_rvalid,
                     mem_addr, mem_dq_out, host_rdata, e.rdy, e.cs_n, e.we_n, e.oe_n, e.dqe, e.rv, e.a, e.d);
         end
      end
   end

   task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      while (!host_ready) @(negedge clk);
      #1 host_req = 1'b1; host_wr = 1'b1; host_addr = a; host_wdata = d;
      @(negedge clk);
      #1 host_req = 1'b0;
   endtask

   task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] expv);
      @(negedge clk);
      while (!host_ready) @(negedge clk);
      #1 host_req = 1'b1; host_wr = 1'b0; host_addr = a;
      @(negedge clk);
      #1 host_req = 1'b0;
      for (int k = 0; k < 50; k++) begin
         @(negedge clk);
         if (host_rvalid) break;
      end
      checks++;
      if (!host_rvalid || host_rdata !== expv) begin // R10 read-back
         errors++;
         $display("FAIL R10 addr %h: got rvalid=%b rdata=%h expected %h", a, host_rvalid, host_rdata, expv);
      end
   endtask

   initial begin
      for (int i = 0; i < 2048; i++) begin
         mdl_mem[i] = '0;
         ref_mem[i] = '0;
      end
      repeat (4) @(negedge clk);
      // R1: reset state
      checks++;
      if (!(host_ready === 1'b1 && mem_cs_n === 1'b1 && mem_we_n === 1'b1 &&
            mem_oe_n === 1'b1 && mem_dq_oe === 1'b0 && host_rvalid === 1'b0)) begin
         errors++;
         $display("FAIL R1 reset: got rdy=%b cs=%b we=%b oe=%b dqe=%b rv=%b expected 1 1 1 1 0 0",
                  host_ready, mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe, host_rvalid);
      end
      #1 rst_n = 1'b1; run_chk = 1'b1;
      repeat (3) @(negedge clk);

      // Address extremes and data patterns (R3, R5, R6)
      do_write(11'd0, 8'h3C);
      do_write(11'd2047, 8'hFF);
      do_write(11'd5, 8'h55);
      do_write(11'd1024, 8'hAA);
      do_write(11'd6, 8'h00);
      do_read(11'd0, 8'h3C);      // R7, R10
      do_read(11'd2047, 8'hFF);
      do_read(11'd5, 8'h55);
      do_read(11'd1024, 8'hAA);
      do_read(11'd6, 8'h00);
      do_read(11'd3, 8'h00);      // never written

      // Write immediately followed by read of the same byte: bus turnaround (R8)
      do_write(11'd100, 8'hC3);
      do_read(11'd100, 8'hC3);
      do_write(11'd100, 8'h81);
      do_write(11'd101, 8'h7E);
      do_read(11'd100, 8'h81);

      // R9: request held during a busy write is ignored
      do_write(11'd7, 8'h12);
      #1 host_req = 1'b1; host_wr = 1'b1; host_addr = 11'd9; host_wdata = 8'h99;
      repeat (2) @(negedge clk);
      #1 host_req = 1'b0;
      do_read(11'd9, 8'h00);      // R9: decoy location untouched
      do_read(11'd7, 8'h12);

      // Spread of addresses and values
      for (int i = 1; i <= 20; i++) do_write(AW'((i * 97) % 2048), DW'(i * 37 + 1));
      for (int i = 1; i <= 20; i++) do_read(AW'((i * 97) % 2048), DW'(i * 37 + 1));

      repeat (10) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule